// File: doc/BRIEF.md
# Boot Partition Key Revocation Gate

This block decides, one boot-image partition at a time, whether that partition may be authenticated, using key state held in one-time-programmable fuses. A sequencer raises `start` with the partition's primary key slot select, its secondary key ID, the revocation scheme it asks for and a flag that marks the first-stage loader. The block then compares the externally computed 384-bit primary key digest with the selected stored digest. It takes the external signature verdict into account and finally checks the secondary key ID. It ends with a one-cycle `done` pulse, plus `accept` or `reject` and a 3-bit reason code.

Two schemes govern secondary key IDs. The first is an exact match against a single 32-bit fuse register. The second is a 256-entry fuse bitmap in which a set bit revokes one ID and leaves the others usable. Either primary slot can also be killed permanently. All fuse state is written through a set-only port: a write can turn bits on and can never turn them off. Hashing and RSA verification lie outside the block and arrive as the `digest_valid` and `sig_ok` inputs.

Top module: `kr_auth_gate`

## Requirements
- R1: The computed digest is compared with stored digest slot `key_sel` (0 or 1). On inequality the partition is rejected with code 1 (digest mismatch).
- R2: A set kill bit for the selected slot rejects with code 2. This takes priority over a digest mismatch. Kill bits, like all fuse bits, cannot be cleared by later writes.
- R3: With `use_bitmap`=0 (equality scheme), a `sk_id` that differs from the 32-bit ID fuse register rejects with code 3. An unprogrammed ID register reads as zero, so ID 0 then passes.
- R4: With `use_bitmap`=1, an ID whose bitmap bit is set rejects with code 4. Any other in-range ID passes, whatever the value of the ID register.
- R5: In the bitmap scheme, ID N in 1..256 maps to bitmap bit N-1. ID 0 or an ID above 256 rejects with code 6.
- R6: A partition with `is_loader`=1 and `use_bitmap`=1 rejects with code 5, ahead of any other ID check.
- R7: While the force-authentication fuse is clear, every request is accepted with code 0 and `done` in the cycle after `start`, without waiting for `digest_valid`.
- R8: Checks run in a fixed order: kill bit and digest (once `digest_valid` is high), then `sig_ok` (code 7 if low), then the ID check. The first failing check gives the code.
- R9: Fuse write port: `fuse_tgt` 0 = digest slot 0 word, 1 = digest slot 1 word, 2 = kill bits (`fuse_wdata[1:0]`), 3 = ID register, 4 = bitmap word, 5 = force fuse (`fuse_wdata[0]`). `fuse_addr` selects the 32-bit word, and word k covers bits 32k+31..32k. Writes OR data into the stored state, and a check started after the write sees it.
- R10: `done` is a one-cycle pulse. `accept` and `reject` are never high together, stay held until the next accepted `start`, and are low while a check runs. No result appears while `digest_valid` stays low. After reset every output is zero.
- R11: Error codes: 0 none, 1 digest mismatch, 2 slot killed, 3 ID mismatch, 4 ID revoked, 5 bitmap scheme on loader, 6 ID out of range, 7 signature fail. `accept` always carries 0 and `reject` never does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check, sampled while idle |
| key_sel | input | 1 | Primary key slot chosen by the partition |
| key_digest | input | 384 | Computed primary key digest |
| digest_valid | input | 1 | Digest is ready |
| sig_ok | input | 1 | Signature verdict from outside |
| sk_id | input | 32 | Secondary key ID of the partition |
| use_bitmap | input | 1 | 1 = bitmap revocation, 0 = equality ID |
| is_loader | input | 1 | Partition is the first-stage loader |
| fuse_we | input | 1 | Fuse write strobe |
| fuse_tgt | input | 3 | Fuse write target |
| fuse_addr | input | 4 | Word index within the target |
| fuse_wdata | input | 32 | Bits to set |
| done | output | 1 | One-cycle completion pulse |
| accept | output | 1 | Partition may be authenticated |
| reject | output | 1 | Partition refused |
| err_code | output | 3 | Rejection reason |

## Verification
The assertions take for granted that fuse writes do not arrive while a check is running. They also assume that `sig_ok` and the request fields stay steady from `start` until `done`, because fuse state is read live and the loader-mode property looks at the force fuse at completion. The stimulus drives all fuse programming only between checks and holds the request fields and `sig_ok` from the cycle of `start` until the result is sampled. A stall case keeps `digest_valid` low for several cycles to show that nothing completes early.

// File: rtl/kr_pkg.sv
package kr_pkg;
    localparam int KR_DIG_W    = 384;
    localparam int KR_WORD_W   = 32;
    localparam int KR_MAP_BITS = 256;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_DIGEST      = 3'd1,
        ERR_KEY_DEAD    = 3'd2,
        ERR_ID_MISMATCH = 3'd3,
        ERR_ID_REVOKED  = 3'd4,
        ERR_LOADER_MODE = 3'd5,
        ERR_ID_RANGE    = 3'd6,
        ERR_SIG         = 3'd7
    } kr_err_e;

    typedef enum logic [2:0] {
        TGT_DIG0  = 3'd0,
        TGT_DIG1  = 3'd1,
        TGT_KILL  = 3'd2,
        TGT_ID    = 3'd3,
        TGT_MAP   = 3'd4,
        TGT_FORCE = 3'd5
    } fuse_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY  = 2'd1,
        ST_SIG  = 2'd2,
        ST_IDV  = 2'd3
    } kr_state_e;
endpackage

// File: rtl/kr_fuse_bank.sv
module kr_fuse_bank
    import kr_pkg::*;
#(
    parameter int DIG_W    = KR_DIG_W,
    parameter int WORD_W   = KR_WORD_W,
    parameter int MAP_BITS = KR_MAP_BITS,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  fuse_tgt_e           tgt,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [DIG_W-1:0]    dig0,
    output logic [DIG_W-1:0]    dig1,
    output logic [1:0]          kill,
    output logic [WORD_W-1:0]   id_reg,
    output logic [MAP_BITS-1:0] map,
    output logic                force_auth
);
    localparam int DIG_WORDS = DIG_W / WORD_W;
    localparam int MAP_WORDS = MAP_BITS / WORD_W;

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dig0       <= '0;
            dig1       <= '0;
            kill       <= '0;
            id_reg     <= '0;
            map        <= '0;
            force_auth <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (we) begin
                for (int k = 0; k < DIG_WORDS; k++) begin
                    if (addr == ADDR_W'(k)) begin
                        if (tgt == TGT_DIG0) dig0[k*WORD_W +: WORD_W] <= dig0[k*WORD_W +: WORD_W] | wdata;
                        if (tgt == TGT_DIG1) dig1[k*WORD_W +: WORD_W] <= dig1[k*WORD_W +: WORD_W] | wdata;
                    end
                end
                for (int m = 0; m < MAP_WORDS; m++) begin
                    if (tgt == TGT_MAP && addr == ADDR_W'(m))
                        map[m*WORD_W +: WORD_W] <= map[m*WORD_W +: WORD_W] | wdata;
                end
                if (tgt == TGT_KILL)  kill       <= kill | wdata[1:0];
                if (tgt == TGT_ID)    id_reg     <= id_reg | wdata;
                if (tgt == TGT_FORCE) force_auth <= force_auth | wdata[0];
            end
        end
    end

    // R2 R9
    fuse_set_only_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ((kill & $past(kill)) == $past(kill)) && ((id_reg & $past(id_reg)) == $past(id_reg)) &&
        ((map & $past(map)) == $past(map)) && (force_auth || !$past(force_auth)));

    // R9
    digest_set_only_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ((dig0 & $past(dig0)) == $past(dig0)) && ((dig1 & $past(dig1)) == $past(dig1)));
endmodule

// File: rtl/kr_id_check.sv
module kr_id_check
    import kr_pkg::*;
#(
    parameter int ID_W     = KR_WORD_W,
    parameter int MAP_BITS = KR_MAP_BITS
) (
    input  logic [ID_W-1:0]     id,
    input  logic                use_map,
    input  logic                loader,
    input  logic [ID_W-1:0]     id_reg,
    input  logic [MAP_BITS-1:0] map,
    output kr_err_e             verdict
);
    localparam int IDX_W = $clog2(MAP_BITS);

    logic [ID_W-1:0] id_m1;
    logic            in_range;

    assign id_m1    = id - ID_W'(1);
    assign in_range = (id != '0) && (id <= ID_W'(MAP_BITS));

    always_comb begin
        if (loader && use_map)           verdict = ERR_LOADER_MODE;
        else if (use_map && !in_range)   verdict = ERR_ID_RANGE;
        else if (use_map)                verdict = map[id_m1[IDX_W-1:0]] ? ERR_ID_REVOKED : ERR_NONE;
        else if (id != id_reg)           verdict = ERR_ID_MISMATCH;
        else                             verdict = ERR_NONE;
    end
endmodule

// File: rtl/kr_auth_gate.sv
module kr_auth_gate
    import kr_pkg::*;
#(
    parameter int DIG_W    = KR_DIG_W,
    parameter int WORD_W   = KR_WORD_W,
    parameter int MAP_BITS = KR_MAP_BITS,
    parameter int ADDR_W   = $clog2((DIG_W / WORD_W) > (MAP_BITS / WORD_W) ?
                                    (DIG_W / WORD_W) : (MAP_BITS / WORD_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              key_sel,
    input  logic [DIG_W-1:0]  key_digest,
    input  logic              digest_valid,
    input  logic              sig_ok,
    input  logic [WORD_W-1:0] sk_id,
    input  logic              use_bitmap,
    input  logic              is_loader,
    input  logic              fuse_we,
    input  logic [2:0]        fuse_tgt,
    input  logic [ADDR_W-1:0] fuse_addr,
    input  logic [WORD_W-1:0] fuse_wdata,
    output logic              done,
    output logic              accept,
    output logic              reject,
    output logic [2:0]        err_code
);
    logic [DIG_W-1:0]    dig0, dig1, sel_dig;
    logic [1:0]          kill;
    logic [WORD_W-1:0]   id_reg;
    logic [MAP_BITS-1:0] map;
    logic                force_auth;

    kr_state_e         st;
    logic              r_sel, r_map, r_ldr;
    logic [WORD_W-1:0] r_id;
    kr_err_e           id_verdict, err_q;

    kr_fuse_bank #(.DIG_W(DIG_W), .WORD_W(WORD_W), .MAP_BITS(MAP_BITS), .ADDR_W(ADDR_W)) i_fuses (
        .clk(clk), .rst(rst), .we(fuse_we), .tgt(fuse_tgt_e'(fuse_tgt)), .addr(fuse_addr),
        .wdata(fuse_wdata), .dig0(dig0), .dig1(dig1), .kill(kill), .id_reg(id_reg),
        .map(map), .force_auth(force_auth)
    );

    kr_id_check #(.ID_W(WORD_W), .MAP_BITS(MAP_BITS)) i_idchk (
        .id(r_id), .use_map(r_map), .loader(r_ldr), .id_reg(id_reg), .map(map),
        .verdict(id_verdict)
    );

    assign sel_dig  = r_sel ? dig1 : dig0;
    assign err_code = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; r_sel <= 1'b0; r_map <= 1'b0; r_ldr <= 1'b0; r_id <= '0;
            done <= 1'b0; accept <= 1'b0; reject <= 1'b0; err_q <= ERR_NONE;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    accept <= 1'b0; reject <= 1'b0; err_q <= ERR_NONE;
                    r_sel <= key_sel; r_id <= sk_id; r_map <= use_bitmap; r_ldr <= is_loader;
                    if (!force_auth) begin
                        done <= 1'b1; accept <= 1'b1;
                    end else begin
                        st <= ST_KEY;
                    end
                end
                ST_KEY: if (digest_valid) begin
                    if (kill[r_sel] || key_digest != sel_dig) begin
                        done <= 1'b1; reject <= 1'b1; st <= ST_IDLE;
                        err_q <= kill[r_sel] ? ERR_KEY_DEAD : ERR_DIGEST;
                    end else begin
                        st <= ST_SIG;
                    end
                end
                ST_SIG: if (!sig_ok) begin
                    done <= 1'b1; reject <= 1'b1; err_q <= ERR_SIG; st <= ST_IDLE;
                end else begin
                    st <= ST_IDV;
                end
                default: begin
                    done <= 1'b1; st <= ST_IDLE; err_q <= id_verdict;
                    accept <= (id_verdict == ERR_NONE);
                    reject <= (id_verdict != ERR_NONE);
                end
            endcase
        end
    end

    // R10
    acc_rej_excl_chk: assert property (@(posedge clk) disable iff (rst) !(accept && reject));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R11
    accept_code_chk: assert property (@(posedge clk) disable iff (rst)
        (accept |-> err_code == 3'd0) and (reject |-> err_code != 3'd0));

    // R6
    loader_bitmap_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && accept && force_auth && r_ldr && r_map));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start && st == ST_IDLE && force_auth) |=> (!accept && !reject && !done));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (start && st == ST_IDLE && !force_auth) |=> (done && accept));
endmodule

// File: tb/test_kr_auth_gate.sv
module test_kr_auth_gate;
    typedef struct packed {
        logic        ppk;
        logic [1:0]  dsrc;
        logic [31:0] id;
        logic        enh;
        logic        ldr;
        logic        sig;
        logic [2:0]  exp;
    } vec_t;

    // ID fuse register = 7, bitmap revokes IDs 3 and 256
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'd7,   1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b1, 2'd1, 32'd7,   1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b0, 2'd2, 32'd7,   1'b0, 1'b0, 1'b1, 3'd1},
        '{1'b1, 2'd0, 32'd7,   1'b0, 1'b0, 1'b1, 3'd1},
        '{1'b0, 2'd0, 32'd6,   1'b0, 1'b0, 1'b1, 3'd3},
        '{1'b0, 2'd0, 32'd7,   1'b0, 1'b0, 1'b0, 3'd7},
        '{1'b0, 2'd2, 32'd7,   1'b0, 1'b0, 1'b0, 3'd1},
        '{1'b0, 2'd0, 32'd1,   1'b1, 1'b0, 1'b1, 3'd0},
        '{1'b0, 2'd0, 32'd3,   1'b1, 1'b0, 1'b1, 3'd4},
        '{1'b0, 2'd0, 32'd256, 1'b1, 1'b0, 1'b1, 3'd4},
        '{1'b0, 2'd0, 32'd255, 1'b1, 1'b0, 1'b1, 3'd0},
        '{1'b0, 2'd0, 32'd0,   1'b1, 1'b0, 1'b1, 3'd6},
        '{1'b0, 2'd0, 32'd257, 1'b1, 1'b0, 1'b1, 3'd6},
        '{1'b0, 2'd0, 32'd1,   1'b1, 1'b1, 1'b1, 3'd5},
        '{1'b0, 2'd0, 32'd7,   1'b0, 1'b1, 1'b1, 3'd0},
        '{1'b0, 2'd0, 32'd3,   1'b1, 1'b0, 1'b0, 3'd7},
        '{1'b0, 2'd0, 32'd4,   1'b1, 1'b0, 1'b1, 3'd0}
    };

    logic         clk = 1'b0, rst = 1'b1, start = 1'b0, key_sel = 1'b0;
    logic [383:0] key_digest = '0;
    logic         digest_valid = 1'b0, sig_ok = 1'b0, use_bitmap = 1'b0, is_loader = 1'b0;
    logic [31:0]  sk_id = '0;
    logic         fuse_we = 1'b0;
    logic [2:0]   fuse_tgt = '0;
    logic [3:0]   fuse_addr = '0;
    logic [31:0]  fuse_wdata = '0;
    logic         done, accept, reject;
    logic [2:0]   err_code;

    int n_chk = 0, n_bad = 0;
    logic g_done, g_acc, g_rej;
    logic [2:0] g_err;
    int g_cyc;

    always #4 clk = ~clk;

    kr_auth_gate i_kr_auth_gate (
        .clk(clk), .rst(rst), .start(start), .key_sel(key_sel), .key_digest(key_digest),
        .digest_valid(digest_valid), .sig_ok(sig_ok), .sk_id(sk_id), .use_bitmap(use_bitmap),
        .is_loader(is_loader), .fuse_we(fuse_we), .fuse_tgt(fuse_tgt), .fuse_addr(fuse_addr),
        .fuse_wdata(fuse_wdata), .done(done), .accept(accept), .reject(reject), .err_code(err_code)
    );

    function automatic logic [383:0] mk_dig(input int s);
        logic [383:0] d;
        for (int k = 0; k < 12; k++) d[k*32 +: 32] = 32'h1000_0000 * (s + 1) + k * 32'h0101_0101;
        return d;
    endfunction

    function automatic logic [383:0] pick_dig(input logic [1:0] src);
        if (src == 2'd2) return mk_dig(0) ^ (384'd1 << 200);
        return mk_dig(int'(src));
    endfunction

    function automatic string req_of(input logic [2:0] e);
        case (e)
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R6";
            3'd6: return "R5";
            3'd7: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fw(input logic [2:0] t, input int a, input logic [31:0] d);
        @(negedge clk);
        fuse_we = 1'b1; fuse_tgt = t; fuse_addr = 4'(a); fuse_wdata = d;
        @(negedge clk);
        fuse_we = 1'b0;
    endtask

    task automatic prog_dig(input int s);
        logic [383:0] d;
        d = mk_dig(s);
        for (int k = 0; k < 12; k++) fw(3'(s), k, d[k*32 +: 32]);
    endtask

    task automatic run(input logic ppk, input logic [1:0] dsrc, input logic [31:0] id,
                       input logic enh, input logic ldr, input logic sig, input int dv_delay);
        @(negedge clk);
        key_sel = ppk; key_digest = pick_dig(dsrc); sk_id = id; use_bitmap = enh;
        is_loader = ldr; sig_ok = sig; digest_valid = (dv_delay == 0); start = 1'b1;
        g_done = 1'b0; g_cyc = 0;
        for (int c = 1; c <= 30 && !g_done; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c >= dv_delay) digest_valid = 1'b1;
            if (done) begin
                g_done = 1'b1; g_acc = accept; g_rej = reject; g_err = err_code; g_cyc = c;
            end
        end
        chk(g_done, "R10 watchdog on done", 0, 1);
        digest_valid = 1'b0;
    endtask

    task automatic expect_res(input logic [2:0] e, input string req);
        chk(g_acc == (e == 3'd0) && g_rej == (e != 3'd0), req, int'({g_acc, g_rej}),
            (e == 3'd0) ? 2 : 1);
        chk(g_err == e, req, int'(g_err), int'(e));
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(!done && !accept && !reject && err_code == 3'd0, "R10 reset",
            int'({done, accept, reject, err_code}), 0);

        // R7 force fuse clear: accepted next cycle, digest never valid
        run(1'b0, 2'd2, 32'd99, 1'b1, 1'b1, 1'b0, 1000);
        expect_res(3'd0, "R7 bypass");
        chk(g_cyc == 1, "R7 latency", g_cyc, 1);

        prog_dig(0);
        prog_dig(1);
        fw(3'd5, 0, 32'd1);

        // R3 unprogrammed ID register reads zero
        run(1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd0, "R3 blank id");

        fw(3'd3, 0, 32'd5);
        run(1'b0, 2'd0, 32'd5, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd0, "R3 id 5");
        // R9 writing zero leaves bits intact
        fw(3'd3, 0, 32'd0);
        run(1'b0, 2'd0, 32'd5, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd0, "R9 zero write");
        // R9 writes OR in: 5 | 2 = 7
        fw(3'd3, 0, 32'd2);
        run(1'b0, 2'd0, 32'd5, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd3, "R9 or-write old id");
        run(1'b0, 2'd0, 32'd7, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd0, "R9 or-write new id");

        fw(3'd4, 0, 32'h0000_0004);
        fw(3'd4, 7, 32'h8000_0000);

        for (int v = 0; v < NV; v++) begin
            run(VECS[v].ppk, VECS[v].dsrc, VECS[v].id, VECS[v].enh, VECS[v].ldr, VECS[v].sig, 0);
            expect_res(VECS[v].exp, req_of(VECS[v].exp));
        end

        // R10 stall: no result while digest_valid low
        run(1'b0, 2'd0, 32'd7, 1'b0, 1'b0, 1'b1, 6);
        chk(g_cyc >= 6, "R10 digest stall", g_cyc, 6);
        expect_res(3'd0, "R10 stall result");

        // R2 kill slot 1
        fw(3'd2, 0, 32'd2);
        run(1'b1, 2'd1, 32'd7, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd2, "R2 killed slot");
        run(1'b1, 2'd2, 32'd7, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd2, "R2 kill over mismatch");
        run(1'b0, 2'd0, 32'd7, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd0, "R2 other slot alive");
        fw(3'd2, 0, 32'd0);
        run(1'b1, 2'd1, 32'd7, 1'b0, 1'b0, 1'b1, 0);
        expect_res(3'd2, "R2 kill sticky");

        // R10 result held, done low afterwards
        repeat (3) @(negedge clk);
        chk(!done && reject && !accept && err_code == 3'd2, "R10 hold",
            int'({done, accept, reject, err_code}), int'({1'b0, 1'b0, 1'b1, 3'd2}));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule